// File: doc/BRIEF.md
# Masked Prioritized Interrupt Encoder

This block gathers fifteen active-low request lines and turns them into a single prioritized interrupt for a processor. Lines 1 to 6 are always interrupt sources. Lines 7 to 15 are shared with general-purpose I/O. Every line is captured on the falling clock edge and inverted, so that a low pin counts as a pending request. The captured request is then gated by that line's enable bit.

On the next rising edge an encoder picks the lowest-numbered pending line and forms a four-bit code and a request flag. Both are re-registered on the following falling edge, so the processor sees stable values that line up with its clock.

Software reaches the block through a bit-addressed control port. A write strobe carries one data bit to one of 32 bit addresses, and one read bit returns the addressed bit. Address 0 holds the mode bit, and interrupt mode is selected when it is 0. In that mode, addresses 1 to 15 write the enable bits and read back the live level of each line. This lets a disabled line act as a plain data input.

Top module: `irq_prio_encoder`

## Requirements
- R1: After reset the outputs are irq_o = 0 and code_o = 4'b1111, all enable bits are 0, and the mode bit reads 0.
- R2: Line k (k = 1..15) is the pin req_n[k-1]. It is captured on the falling clock edge and held for a full clock period. A low pin counts as a pending request.
- R3: A pending line takes part in encoding only while its enable bit is 1. A line whose enable bit is 0 never raises irq_o.
- R4: When no enabled line is pending, irq_o is 0 and code_o is 4'b1111.
- R5: When any enabled line is pending, irq_o is 1 and code_o equals the number of the lowest-numbered enabled pending line.
- R6: A pin change that is set up before falling edge F0 is encoded on the rising edge after F0. It appears on irq_o/code_o only after the next falling edge F1, and the outputs do not change before F1.
- R7: With the mode bit at 0, a write strobe on rising edge with cb_addr = k (1..15) sets the enable bit of line k to cb_wdata. The other enable bits are left unchanged.
- R8: With the mode bit at 0, cb_rdata for cb_addr = k (1..15) equals the captured level of pin req_n[k-1], without inversion. cb_rdata for cb_addr = 0 returns the mode bit.
- R9: A write to cb_addr = 0 sets the mode bit to cb_wdata. While the mode bit is 1, writes to addresses 1..15 leave the enable bits unchanged, and reads of addresses 1..15 return 0.
- R10: Addresses 16..31 change nothing on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture and synchronizing on falling edge, encoding and control writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 15 | Active-low request lines, bit k-1 is line k |
| cb_addr | input | 5 | Bit address of the control port |
| cb_wr | input | 1 | Write strobe, taken on the rising edge |
| cb_wdata | input | 1 | Write data bit |
| cb_rdata | output | 1 | Read data bit for cb_addr |
| irq_o | output | 1 | Synchronized interrupt request |
| code_o | output | 4 | Synchronized priority code |

## Verification
The hardest case to reach from the ports is a lower-priority line winning only because every line below it is pending but disabled. That case needs both the request pattern and the enable pattern to vary. The stimulus first sweeps all 32768 request patterns with every line enabled. It then repeats a sweep under a sparse enable pattern written one bit at a time, so that disabled low-numbered lines sit pending beneath enabled higher ones. A separate test probes the half-cycle pipeline by sampling the outputs between the encoding edge and the synchronizing edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LINES  = 15;
  localparam int CODE_W = 4;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic              hit;
    logic [CODE_W-1:0] code;
  } prio_t;

  // Lowest-numbered set bit wins; bit i is line i+1. Idle code is all ones.
  function automatic prio_t prio_encode(input logic [LINES-1:0] pend);
    prio_t r;
    r.hit  = 1'b0;
    r.code = '1;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        r.hit  = 1'b1;
        r.code = CODE_W'(i + 1);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int N_LINES = irq_pkg::LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_n,
  output logic [N_LINES-1:0] pend_raw
);
  // One capture flop per line, falling edge, inverted on capture.
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pend_raw[g] <= 1'b0;
      else        pend_raw[g] <= ~req_n[g];
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int N_LINES = irq_pkg::LINES,
  parameter int ADDR_W  = irq_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cb_addr,
  input  logic               cb_wr,
  input  logic               cb_wdata,
  input  logic [N_LINES-1:0] pend_raw,
  output logic [N_LINES-1:0] enable,
  output logic               mode,
  output logic               cb_rdata
);
  logic [N_LINES-1:0] sel;

  for (genvar g = 0; g < N_LINES; g++) begin : g_dec
    assign sel[g] = (cb_addr == ADDR_W'(g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      mode   <= 1'b0;
    end else if (cb_wr) begin
      if (cb_addr == '0) mode <= cb_wdata;
      else if (!mode) begin
        for (int i = 0; i < N_LINES; i++)
          if (sel[i]) enable[i] <= cb_wdata;
      end
    end
  end

  // Read path: address 0 gives the mode bit, 1..N give the pin level.
  always_comb begin
    cb_rdata = 1'b0;
    if (cb_addr == '0) cb_rdata = mode;
    else if (!mode) begin
      for (int i = 0; i < N_LINES; i++)
        if (sel[i]) cb_rdata = ~pend_raw[i];
    end
  end
endmodule

// File: rtl/irq_prio_stage.sv
module irq_prio_stage #(
  parameter int N_LINES = irq_pkg::LINES,
  parameter int CODE_W  = irq_pkg::CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pend_raw,
  input  logic [N_LINES-1:0] enable,
  output logic [N_LINES-1:0] pend_gated,
  output logic               enc_irq,
  output logic [CODE_W-1:0]  enc_code
);
  irq_pkg::prio_t nxt;

  assign pend_gated = pend_raw & enable;

  always_comb nxt = irq_pkg::prio_encode(pend_gated);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_irq  <= 1'b0;
      enc_code <= '1;
    end else begin
      enc_irq  <= nxt.hit;
      enc_code <= nxt.code;
    end
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int N_LINES = irq_pkg::LINES,
  parameter int CODE_W  = irq_pkg::CODE_W,
  parameter int ADDR_W  = irq_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_n,
  input  logic [ADDR_W-1:0]  cb_addr,
  input  logic               cb_wr,
  input  logic               cb_wdata,
  output logic               cb_rdata,
  output logic               irq_o,
  output logic [CODE_W-1:0]  code_o
);
  // Named internal events, visible to the bound checker.
  logic [N_LINES-1:0] pend_raw;
  logic [N_LINES-1:0] pend_gated;
  logic [N_LINES-1:0] enable;
  logic               mode;
  logic               enc_irq;
  logic [CODE_W-1:0]  enc_code;

  irq_sampler #(.N_LINES(N_LINES)) u_smp (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .pend_raw(pend_raw)
  );

  irq_ctrl_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cb_addr(cb_addr), .cb_wr(cb_wr),
    .cb_wdata(cb_wdata), .pend_raw(pend_raw), .enable(enable),
    .mode(mode), .cb_rdata(cb_rdata)
  );

  irq_prio_stage #(.N_LINES(N_LINES), .CODE_W(CODE_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .pend_raw(pend_raw), .enable(enable),
    .pend_gated(pend_gated), .enc_irq(enc_irq), .enc_code(enc_code)
  );

  // Synchronizing register on the falling edge after encoding.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      code_o <= '1;
    end else begin
      irq_o  <= enc_irq;
      code_o <= enc_code;
    end
  end
endmodule

// File: rtl/irq_prio_encoder_chk.sv
module irq_prio_encoder_chk #(
  parameter int N_LINES = irq_pkg::LINES,
  parameter int CODE_W  = irq_pkg::CODE_W,
  parameter int ADDR_W  = irq_pkg::ADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  cb_addr,
  input logic               cb_wr,
  input logic               irq_o,
  input logic [CODE_W-1:0]  code_o,
  input logic [N_LINES-1:0] pend_gated,
  input logic [N_LINES-1:0] enable,
  input logic               mode,
  input logic               enc_irq,
  input logic [CODE_W-1:0]  enc_code
);
  logic [N_LINES-1:0] pend_q;
  logic               win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_gated;
  end

  // Winner bit is set and no lower-numbered bit is set.
  always_comb begin
    win_ok = 1'b0;
    for (int i = 0; i < N_LINES; i++)
      if (enc_code == CODE_W'(i + 1))
        win_ok = pend_q[i] && ((pend_q & ((N_LINES'(1) << i) - 1'b1)) == '0);
  end

  a_r4_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> code_o == '1);

  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    enc_irq |-> win_ok);

  a_r3_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !enc_irq);

  a_r6_sync_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == enc_irq) && (code_o == enc_code));

  a_r9_mode_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && cb_wr && cb_addr != '0) |=> $stable(enable));

  a_r10_high_addr_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_wr && cb_addr > ADDR_W'(N_LINES)) |=> $stable(enable) && $stable(mode));
endmodule

bind irq_prio_encoder irq_prio_encoder_chk #(
  .N_LINES(N_LINES), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cb_addr(cb_addr), .cb_wr(cb_wr),
  .irq_o(irq_o), .code_o(code_o), .pend_gated(pend_gated),
  .enable(enable), .mode(mode), .enc_irq(enc_irq), .enc_code(enc_code)
);

// File: tb/irq_prio_encoder_tb.sv
module irq_prio_encoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] req_n = '1;
  logic [4:0]  cb_addr = '0;
  logic        cb_wr = 1'b0;
  logic        cb_wdata = 1'b0;
  logic        cb_rdata;
  logic        irq_o;
  logic [3:0]  code_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cb_addr(cb_addr),
    .cb_wr(cb_wr), .cb_wdata(cb_wdata), .cb_rdata(cb_rdata),
    .irq_o(irq_o), .code_o(code_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected result, counted upward from line 1.
  function automatic logic [4:0] expect_out(input logic [14:0] pins, input logic [14:0] en);
    for (int k = 1; k <= 15; k++)
      if (!pins[k-1] && en[k-1]) return {1'b1, 4'(k)};
    return 5'b0_1111;
  endfunction

  task automatic cb_write(input logic [4:0] a, input logic d);
    @(posedge clk); #1;
    cb_addr = a; cb_wr = 1'b1; cb_wdata = d;
    @(posedge clk); #1;
    cb_wr = 1'b0;
  endtask

  task automatic set_enables(input logic [14:0] en);
    for (int k = 1; k <= 15; k++) cb_write(5'(k), en[k-1]);
  endtask

  // Drive after a rising edge, check after the second falling edge.
  task automatic apply_check(input string req, input logic [14:0] pins, input logic [14:0] en);
    @(posedge clk); #1;
    req_n = pins;
    @(negedge clk); @(negedge clk); #1;
    chk(req, {3'b0, irq_o, code_o}, {3'b0, expect_out(pins, en)});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [14:0] en;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, while reset is still held
    chk("R1 irq", {7'b0, irq_o}, 8'h0);
    chk("R1 code", {4'b0, code_o}, 8'h0f);
    rst_n = 1'b1;
    @(negedge clk); #1;
    cb_addr = 5'd0;
    chk("R1 mode reads 0", {7'b0, cb_rdata}, 8'h0);
    // R1/R3: enables start at 0, so all lines pending gives no request
    apply_check("R1 R3 zero enables", 15'h0000, 15'h0000);

    // R7 write enables; R5 full sweep with every line enabled
    set_enables(15'h7fff);
    for (int p = 0; p < 32768; p++)
      apply_check("R5 sweep all enabled", 15'(p), 15'h7fff);
    apply_check("R4 idle", 15'h7fff, 15'h7fff);

    // R3 R5: sparse enables, low lines pending but disabled
    en = 15'b101_0010_0100_1000;
    set_enables(en);
    for (int p = 0; p < 4096; p++)
      apply_check("R3 R5 sparse enables", {3'b111, 12'(p)}, en);
    apply_check("R3 disabled lines only", ~(~en & 15'h7fff) | en ^ en, en);

    // R7 single-bit write keeps other enables
    cb_write(5'd4, 1'b1);
    en[3] = 1'b1;
    apply_check("R7 single write", 15'h7ff7 & 15'h7ff5, en);

    // R6 pipeline timing
    set_enables(15'h7fff);
    apply_check("R6 idle before", 15'h7fff, 15'h7fff);
    @(posedge clk); #1;
    req_n = 15'h7ffb; // line 3
    @(negedge clk); #1;
    chk("R6 unchanged after capture", {3'b0, irq_o, code_o}, 8'h0f);
    @(posedge clk); #1;
    chk("R6 unchanged after encode", {3'b0, irq_o, code_o}, 8'h0f);
    @(negedge clk); #1;
    chk("R6 visible after sync edge", {3'b0, irq_o, code_o}, 8'h13);

    // R2 R8 readback of pin level per line
    for (int k = 1; k <= 15; k++) begin
      @(posedge clk); #1;
      req_n = 15'h7fff ^ (15'(1) << (k - 1));
      cb_addr = 5'(k);
      @(negedge clk); #1;
      chk("R8 read low line", {7'b0, cb_rdata}, 8'h0);
      @(posedge clk); #1;
      req_n = 15'h7fff;
      @(negedge clk); #1;
      chk("R2 R8 read high line", {7'b0, cb_rdata}, 8'h1);
    end

    // R10 high addresses: reads 0, writes inert
    for (int a = 16; a < 32; a++) begin
      cb_write(5'(a), 1'b1);
      cb_addr = 5'(a);
      #1;
      chk("R10 high read", {7'b0, cb_rdata}, 8'h0);
    end
    cb_addr = 5'd0; #1;
    chk("R10 mode untouched", {7'b0, cb_rdata}, 8'h0);
    apply_check("R10 enables untouched", 15'h7ffe, 15'h7fff);

    // R9 mode bit
    cb_write(5'd0, 1'b1);
    cb_addr = 5'd0; #1;
    chk("R9 mode reads 1", {7'b0, cb_rdata}, 8'h1);
    cb_write(5'd1, 1'b0);
    cb_write(5'd2, 1'b0);
    cb_addr = 5'd5; req_n = 15'h0000;
    @(negedge clk); #1;
    chk("R9 read blocked", {7'b0, cb_rdata}, 8'h0);
    cb_write(5'd0, 1'b0);
    apply_check("R9 writes ignored in mode 1", 15'h7ffe, 15'h7fff);
    apply_check("R9 line 2 still enabled", 15'h7ffd, 15'h7fff);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule